// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

This block drives a time-multiplexed LED panel. It scans 4 to 7 grid (digit) lines one at a time. While a grid line is active, the block drives up to 12 segment lines from the two display-memory bytes that belong to that digit. Each grid slot lasts 16 slot ticks. The segment lines are enabled only for the first part of the slot, and a 3-bit code picks that length from a non-uniform table, which dims the panel.

A 2-bit mode code sets the split between digits and segments. More digits means fewer segments, because three output pins are shared between the top segments and the top grids. A command decoder elsewhere supplies the mode code, the display-on flag and the dimming code. These three controls are registered inside the block. A clock divider supplies a one-cycle slot tick. Display memory is read through a combinational port: the block presents the even byte address, and the memory returns that byte together with the low nibble of the following byte in the same cycle.

Top module: `led_grid_scan`

## Requirements
- R1: The registered mode code m selects 4+m digits. The grid index steps 1, 2, …, 4+m and then wraps back to 1. At most one grid enable is high at any time.
- R2: The registered mode code m selects 12−m active segments. Segment enables numbered above 12−m are always 0.
- R3: Shared pin 0 carries grid 7 when 7 digits are active, and segment 10 otherwise. Shared pin 1 carries grid 6 when at least 6 digits are active, and segment 11 otherwise. Shared pin 2 carries grid 5 when at least 5 digits are active, and segment 12 otherwise.
- R4: For digit n (1 to 7), the read address is 2(n−1). Bits 7:0 of the even byte drive segments 8 to 1, with bit 0 driving segment 1. Bits 3:0 of the following byte drive segments 12 to 9.
- R5: The registered dim code selects the segment on-time per slot. Codes 0 to 7 give 1, 2, 4, 10, 11, 12, 13 and 14 ticks of 16, counted from the start of the slot. Segments are never on in ticks 14 and 15.
- R6: The tick counter advances only on cycles where slot_tick is high. The grid index advances when the counter passes from 15 to 0. The grid enable stays high for the whole slot.
- R7: While the registered display-on flag is 0, every segment, grid and shared output is 0. Scanning continues in the background.
- R8: After reset the registered controls are mode 3 (7 digits, 9 segments), display off and dim code 0. The tick counter and grid index start at 0 (digit 1). The controls are sampled every clock and act one cycle later.
- R9: When the mode code input differs from the registered mode, the next cycle starts digit 1 at tick 0. This takes priority over slot_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Digit/segment split code |
| disp_on | input | 1 | Display enable flag |
| dim_sel | input | 3 | Dimming code |
| slot_tick | input | 1 | One-cycle tick from the divider |
| rd_addr | output | 4 | Even byte address of the current digit |
| rd_lo | input | 8 | Memory byte at rd_addr |
| rd_hi_nib | input | 4 | Low nibble of the byte at rd_addr+1 |
| seg_en | output | 12 | Segment enables, bit 0 = segment 1 |
| grid_en | output | 7 | Grid enables, bit 0 = grid 1 |
| shared_pin | output | 3 | Shared segment/grid pins (seg10/grid7, seg11/grid6, seg12/grid5) |

## Verification
The bench builds the block with its default 4-bit tick counter, so one slot is 16 ticks. This keeps every dim step, every grid wrap in all four modes and every shared-pin role reachable within a few hundred cycles. A behavioural model, checked every clock, covers gaps in slot_tick, mode changes in the middle of a slot, and toggling of the display flag. Directed slot-aligned runs measure the on-time for all eight dim codes.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
    localparam int MODE_W = 2;
    localparam int DIM_W  = 3;
    localparam int SEG_MAX = 12;
    localparam int DIG_MAX = 7;

    // number of digits scanned for a mode code
    function automatic logic [2:0] digits_of(input logic [MODE_W-1:0] m);
        return 3'd4 + {1'b0, m};
    endfunction

    // number of active segments for a mode code
    function automatic logic [3:0] segs_of(input logic [MODE_W-1:0] m);
        return 4'd12 - {2'b00, m};
    endfunction

    // on-time in sixteenths of a slot
    function automatic logic [3:0] sixteenths(input logic [DIM_W-1:0] c);
        case (c)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            default: return 4'd7 + {1'b0, c};
        endcase
    endfunction
endpackage

// File: rtl/lgs_duty.sv
module lgs_duty #(
    parameter int TICK_W = 4
) (
    input  logic [lgs_pkg::DIM_W-1:0] dim,
    input  logic [TICK_W-1:0]         tick,
    output logic                      gate
);
    localparam int SCALE = TICK_W - 4;
    logic [TICK_W:0] width;

    always_comb begin
        width = {{(TICK_W-3){1'b0}}, lgs_pkg::sixteenths(dim)} << SCALE;
        gate  = ({1'b0, tick} < width);
    end
endmodule

// File: rtl/lgs_seg_map.sv
module lgs_seg_map (
    input  logic [lgs_pkg::MODE_W-1:0]  mode,
    input  logic [7:0]                  lo,
    input  logic [3:0]                  hi,
    output logic [lgs_pkg::SEG_MAX-1:0] pattern
);
    logic [3:0] nseg;
    assign nseg = lgs_pkg::segs_of(mode);

    for (genvar i = 0; i < lgs_pkg::SEG_MAX; i++) begin : g_seg
        logic raw;
        if (i < 8) begin : g_lo
            assign raw = lo[i];
        end else begin : g_hi
            assign raw = hi[i-8];
        end
        assign pattern[i] = raw & (4'(i) < nseg);
    end
endmodule

// File: rtl/lgs_pin_mux.sv
module lgs_pin_mux (
    input  logic [lgs_pkg::MODE_W-1:0]  mode,
    input  logic [lgs_pkg::SEG_MAX-1:0] seg,
    input  logic [lgs_pkg::DIG_MAX-1:0] grid,
    output logic [2:0]                  pin
);
    logic [2:0] ndig;
    assign ndig = lgs_pkg::digits_of(mode);

    for (genvar k = 0; k < 3; k++) begin : g_pin
        assign pin[k] = (ndig >= 3'(7 - k)) ? grid[6-k] : seg[9+k];
    end
endmodule

// File: rtl/led_grid_scan.sv
module led_grid_scan #(
    parameter int TICK_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_sel,
    input  logic        disp_on,
    input  logic [2:0]  dim_sel,
    input  logic        slot_tick,
    output logic [3:0]  rd_addr,
    input  logic [7:0]  rd_lo,
    input  logic [3:0]  rd_hi_nib,
    output logic [11:0] seg_en,
    output logic [6:0]  grid_en,
    output logic [2:0]  shared_pin
);
    import lgs_pkg::*;

    localparam int GRID_W = $clog2(DIG_MAX);
    localparam logic [TICK_W-1:0] TICK_LAST = {TICK_W{1'b1}};

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              on;
        logic [DIM_W-1:0]  dim;
        logic [TICK_W-1:0] tick;
        logic [GRID_W-1:0] grid;
    } scan_t;

    scan_t st_d, st_q;
    logic [SEG_MAX-1:0] pattern;
    logic               gate;
    logic [2:0]         ndig;

    assign ndig = digits_of(st_q.mode);

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_sel;
        st_d.on   = disp_on;
        st_d.dim  = dim_sel;
        if (mode_sel != st_q.mode) begin
            st_d.tick = '0;
            st_d.grid = '0;
        end else if (slot_tick) begin
            st_d.tick = st_q.tick + 1'b1;
            if (st_q.tick == TICK_LAST) begin
                st_d.grid = (st_q.grid == GRID_W'(ndig - 3'd1)) ? '0 : st_q.grid + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: 2'b11, on: 1'b0, dim: '0, tick: '0, grid: '0};
        end else begin
            st_q <= st_d;
        end
    end

    lgs_duty #(.TICK_W(TICK_W)) u_duty (
        .dim  (st_q.dim),
        .tick (st_q.tick),
        .gate (gate)
    );

    lgs_seg_map u_map (
        .mode    (st_q.mode),
        .lo      (rd_lo),
        .hi      (rd_hi_nib),
        .pattern (pattern)
    );

    assign rd_addr = {st_q.grid, 1'b0};
    assign grid_en = st_q.on ? (7'd1 << st_q.grid) : 7'd0;
    assign seg_en  = (st_q.on && gate) ? pattern : 12'd0;

    lgs_pin_mux u_mux (
        .mode (st_q.mode),
        .seg  (seg_en),
        .grid (grid_en),
        .pin  (shared_pin)
    );

    // exported for the bound checker
    logic [1:0]        mode_q_w;
    logic              on_q_w;
    logic [TICK_W-1:0] tick_q_w;
    logic [GRID_W-1:0] grid_q_w;
    assign mode_q_w = st_q.mode;
    assign on_q_w   = st_q.on;
    assign tick_q_w = st_q.tick;
    assign grid_q_w = st_q.grid;
endmodule

module led_grid_scan_chk #(
    parameter int TICK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              slot_tick,
    input logic [1:0]        mode_q_w,
    input logic              on_q_w,
    input logic [TICK_W-1:0] tick_q_w,
    input logic [2:0]        grid_q_w,
    input logic [11:0]       seg_en,
    input logic [6:0]        grid_en,
    input logic [2:0]        shared_pin
);
    // R1
    grid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_en));
    // R1
    grid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, grid_q_w} < (4'd4 + {2'b00, mode_q_w})));
    // R2
    seg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_en >> (4'd12 - {2'b00, mode_q_w})) == 12'd0));
    // R5
    dim_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q_w >= TICK_W'(14 << (TICK_W - 4))) |-> (seg_en == 12'd0));
    // R6
    grid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_tick && mode_sel == mode_q_w) |=> $stable(grid_q_w) && $stable(tick_q_w));
    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q_w |-> (grid_en == 7'd0 && seg_en == 12'd0 && shared_pin == 3'd0));
    // R9
    mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != mode_q_w) |=> (grid_q_w == 3'd0 && tick_q_w == '0));
endmodule

bind led_grid_scan led_grid_scan_chk #(.TICK_W(TICK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .slot_tick  (slot_tick),
    .mode_q_w   (mode_q_w),
    .on_q_w     (on_q_w),
    .tick_q_w   (tick_q_w),
    .grid_q_w   (grid_q_w),
    .seg_en     (seg_en),
    .grid_en    (grid_en),
    .shared_pin (shared_pin)
);

// File: tb/tb_led_grid_scan.sv
module tb_led_grid_scan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b11;
    logic        disp_on = 1'b0;
    logic [2:0]  dim_sel = 3'd0;
    logic        slot_tick = 1'b0;
    logic [3:0]  rd_addr;
    logic [7:0]  rd_lo;
    logic [3:0]  rd_hi_nib;
    logic [11:0] seg_en;
    logic [6:0]  grid_en;
    logic [2:0]  shared_pin;

    logic [7:0] mem [0:15];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mode, m_on, m_dim, m_tick, m_grid;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_lo     = mem[rd_addr];
    assign rd_hi_nib = mem[rd_addr + 4'd1][3:0];

    led_grid_scan dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .disp_on(disp_on),
        .dim_sel(dim_sel), .slot_tick(slot_tick), .rd_addr(rd_addr),
        .rd_lo(rd_lo), .rd_hi_nib(rd_hi_nib), .seg_en(seg_en),
        .grid_en(grid_en), .shared_pin(shared_pin)
    );

    function automatic int width_of(int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 10;
            4: return 11; 5: return 12; 6: return 13; default: return 14;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 3; m_on <= 0; m_dim <= 0; m_tick <= 0; m_grid <= 0;
        end else begin
            m_mode <= mode_sel;
            m_on   <= disp_on;
            m_dim  <= dim_sel;
            if (int'(mode_sel) != m_mode) begin
                m_tick <= 0; m_grid <= 0;
            end else if (slot_tick) begin
                m_tick <= (m_tick + 1) % 16;
                if (m_tick == 15) m_grid <= (m_grid + 1 == 4 + m_mode) ? 0 : m_grid + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int pat, nseg, s, g, sh;
        nseg = 12 - m_mode;
        pat = mem[2*m_grid] | ((mem[2*m_grid+1] & 15) << 8);
        pat = pat & ((1 << nseg) - 1);
        s = (m_on != 0 && m_tick < width_of(m_dim)) ? pat : 0;
        g = (m_on != 0) ? (1 << m_grid) : 0;
        sh = 0;
        for (int k = 0; k < 3; k++) begin
            int bitv;
            if (4 + m_mode >= 7 - k) bitv = (g >> (6 - k)) & 1;
            else bitv = (s >> (9 + k)) & 1;
            sh |= bitv << k;
        end
        check("R4 rd_addr", int'(rd_addr), 2*m_grid);
        check("R1/R6/R7 grid_en", int'(grid_en), g);
        check("R2/R4/R5 seg_en", int'(seg_en), s);
        check("R3 shared_pin", int'(shared_pin), sh);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 91);
        repeat (2) @(negedge clk);
        // R8 reset state
        check("R8 reset grid_en", int'(grid_en), 0);
        check("R8 reset seg_en", int'(seg_en), 0);
        check("R8 reset rd_addr", int'(rd_addr), 0);
        rst_n = 1'b1;
        // R7: off, scanning in background with ticks
        slot_tick = 1'b1;
        step(40);
        // R8: reset mode 3 kept, turn on, full scan of 7 digits
        disp_on = 1'b1; dim_sel = 3'd7;
        step(16 * 8);
        // R1/R3 each mode, gaps in slot_tick
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            dim_sel = 3'(m + 3);
            for (int i = 0; i < 16 * (5 + m); i++) begin
                @(negedge clk);
                compare();
                slot_tick = (i % 3) != 1;
            end
            slot_tick = 1'b1;
        end
        // R9 mode change mid-slot
        step(7);
        mode_sel = 2'd1;
        step(20);
        // R7 toggle display flag while scanning
        disp_on = 1'b0;
        step(25);
        disp_on = 1'b1;
        step(10);
        // R5 directed on-time per dim code, slot aligned
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        for (int c = 0; c < 8; c++) begin
            int cnt;
            cnt = 0;
            dim_sel = 3'(c);
            mode_sel = 2'(c % 2 == 0 ? 0 : 1);
            @(negedge clk);
            compare();
            for (int t = 0; t < 16; t++) begin
                if (seg_en != 12'd0) cnt++;
                @(negedge clk);
                compare();
            end
            check("R5 on-time ticks", cnt, width_of(c));
        end
        // R2: pattern with every bit set in mode 2, all segments beyond 10 low
        mode_sel = 2'd2; dim_sel = 3'd7;
        step(2);
        check("R2 seg limit", int'(seg_en[11:10]), 0);
        step(60);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule